// File: doc/BRIEF.md
# Eye-Centering Delay Calibrator

This block tunes a tap-programmable delay line so that the capture strobe lands in the middle of the data eye. During calibration it drives every tap setting in turn, from the lowest to the highest. At each setting it waits for the line to settle. It then asks the external capture logic to sample a known pattern and report whether the sample matched.

Once the last tap has been graded, the block takes the longest unbroken run of passing taps as the eye. It programs the middle tap of that run. If no run is long enough, the old setting is kept and an error flag is raised. A sweep starts either on a one-cycle start pulse or when a programmable idle-interval timer expires. Delays drift with temperature and voltage, so the timer allows repeated recalibration.

Each sweep first asks the memory controller to give up the channel. The sweep begins only once the controller grants it. The channel stays claimed until the new setting is in place.

Top module: `eyeCenterCal`

## Requirements
- R1: After reset, `delayTap` is 32, and `busy`, `calReq`, `cmpReq` and `calErr` are all 0.
- R2: A one-cycle `calStart` pulse, or expiry of the interval timer, raises `calReq` on the next cycle. While `idleGrant` stays low, `busy` and `cmpReq` stay 0 and `delayTap` does not change.
- R3: After the grant, the sweep drives `delayTap` through 0, 1, 2 … 63. Each value is presented exactly once, in rising order, while `busy` is 1.
- R4: After each new tap value, including the first, exactly 8 cycles pass with `cmpReq` low before `cmpReq` rises. `cmpReq` stays high until `cmpDone` is seen. `cmpPass` sampled with `cmpDone` grades that tap (1 = pass).
- R5: After tap 63 is graded, the applied tap is S + (L−1)/2, rounded down. Here S is the first tap and L the length of the longest contiguous run of passing taps. On a tie, the run with the lowest taps wins.
- R6: Runs shorter than 2 taps do not count. If no run of at least 2 taps exists, the applied tap keeps its previous value and `calErr` is set to 1. Any successful calibration clears `calErr` to 0.
- R7: `busy` stays high from the first settle cycle through one cycle after the last grading. While `busy` is 0, `delayTap` shows the applied tap, which changes only on the cycle `busy` falls. `calReq` is high whenever `busy` is high.
- R8: When `intervalCfg` is N ≠ 0, `calReq` rises after exactly N idle cycles following the end of a calibration. When `intervalCfg` is 0, the timer never requests a calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calStart | input | 1 | One-cycle request to start a calibration |
| intervalCfg | input | IV_W (16) | Idle cycles between automatic calibrations; 0 disables the timer |
| idleGrant | input | 1 | Controller grants the idle channel |
| calReq | output | 1 | Channel request, held from trigger until the new tap is applied |
| cmpReq | output | 1 | Request to capture and compare the expected pattern |
| cmpDone | input | 1 | Compare result valid |
| cmpPass | input | 1 | Compare matched (valid with cmpDone) |
| busy | output | 1 | Sweep in progress |
| delayTap | output | TAP_W (6) | Tap value driven to the delay line |
| calErr | output | 1 | Last calibration found no usable window |

## Verification
The hardest cases to reach from the ports are the rules for choosing the window. These include runs that touch tap 0 or tap 63, two runs of equal length, and patterns where only isolated single passes occur. Each of these needs a specific pass/fail answer at each of 64 taps, set well in advance.

The bench acts as the capture logic. It answers every compare request with one bit of a 64-bit pass mask, so any window shape can be set up directly. The masks include edge-touching, tied, empty and all-pass cases, plus pseudo-random ones. The bench computes the expected tap from each mask by a simple scan of its own.

The interval timer is checked by counting idle cycles after a sweep ends.

// File: rtl/eyeCalPkg.sv
package eyeCalPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_SETTLE,
    S_CMP,
    S_FIN
  } calStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // restart sweep bookkeeping at tap 0
    logic record;  // grade current tap with cmpPass
    logic step;    // advance sweep tap
    logic apply;   // commit window midpoint (or flag error)
  } calStrobeT;

endpackage

// File: rtl/eyeCalCtrl.sv
module eyeCalCtrl
  import eyeCalPkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int IV_W       = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            calStart,
  input  logic [IV_W-1:0] intervalCfg,
  input  logic            idleGrant,
  input  logic            cmpDone,
  input  logic            tapAtMax,
  output calStrobeT       strb,
  output logic            calReq,
  output logic            cmpReq,
  output logic            busy
);

  localparam int SC_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_CYC - 1);

  calStateT        state, nxt;
  logic [SC_W-1:0] sCnt;
  logic [IV_W-1:0] ivCnt;
  logic            ivHit;

  assign ivHit = (state == S_IDLE) && (intervalCfg != '0) &&
                 ((ivCnt + IV_W'(1)) >= intervalCfg);

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      S_IDLE:   if (calStart || ivHit) nxt = S_REQ;
      S_REQ:    if (idleGrant) begin
                  strb.clear = 1'b1;
                  nxt        = S_SETTLE;
                end
      S_SETTLE: if (sCnt == SC_LAST) nxt = S_CMP;
      S_CMP:    if (cmpDone) begin
                  strb.record = 1'b1;
                  if (tapAtMax) nxt = S_FIN;
                  else begin
                    strb.step = 1'b1;
                    nxt       = S_SETTLE;
                  end
                end
      S_FIN: begin
        strb.apply = 1'b1;
        nxt        = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      sCnt  <= '0;
      ivCnt <= '0;
    end else begin
      state <= nxt;
      sCnt  <= (state == S_SETTLE) ? sCnt + SC_W'(1) : '0;
      if (state != S_IDLE || ivHit)  ivCnt <= '0;
      else if (intervalCfg != '0)    ivCnt <= ivCnt + IV_W'(1);
    end
  end

  assign calReq = (state != S_IDLE);
  assign cmpReq = (state == S_CMP);
  assign busy   = (state == S_SETTLE) || (state == S_CMP) || (state == S_FIN);

endmodule

// File: rtl/eyeCalPath.sv
module eyeCalPath
  import eyeCalPkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int MIN_RUN   = 2,
  parameter int RESET_TAP = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrobeT        strb,
  input  logic             cmpPass,
  output logic             tapAtMax,
  output logic [TAP_W-1:0] sweepTap,
  output logic [TAP_W-1:0] appliedTap,
  output logic             calErr
);

  localparam int LEN_W = TAP_W + 1;
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_RUN);

  logic [TAP_W-1:0] runStart, bestStart, curStart;
  logic [LEN_W-1:0] runLen, bestLen, curLen, midSum;

  assign tapAtMax = (sweepTap == {TAP_W{1'b1}});
  assign curStart = (runLen == '0) ? sweepTap : runStart;
  assign curLen   = runLen + LEN_W'(1);
  assign midSum   = {1'b0, bestStart} + ((bestLen - LEN_W'(1)) >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sweepTap   <= '0;
      runStart   <= '0;
      runLen     <= '0;
      bestStart  <= '0;
      bestLen    <= '0;
      appliedTap <= TAP_W'(RESET_TAP);
      calErr     <= 1'b0;
    end else begin
      if (strb.clear) begin
        sweepTap  <= '0;
        runStart  <= '0;
        runLen    <= '0;
        bestStart <= '0;
        bestLen   <= '0;
      end
      if (strb.record) begin
        if (cmpPass) begin
          runStart <= curStart;
          runLen   <= curLen;
          // strictly longer: on a tie the earlier run is kept
          if (curLen > bestLen) begin
            bestStart <= curStart;
            bestLen   <= curLen;
          end
        end else begin
          runLen <= '0;
        end
      end
      if (strb.step) sweepTap <= sweepTap + TAP_W'(1);
      if (strb.apply) begin
        if (bestLen >= MIN_LEN) begin
          appliedTap <= midSum[TAP_W-1:0];
          calErr     <= 1'b0;
        end else begin
          calErr <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/eyeCenterCal.sv
module eyeCenterCal
  import eyeCalPkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int IV_W       = 16,
  parameter int SETTLE_CYC = 8,
  parameter int MIN_RUN    = 2,
  parameter int RESET_TAP  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             calStart,
  input  logic [IV_W-1:0]  intervalCfg,
  input  logic             idleGrant,
  output logic             calReq,
  output logic             cmpReq,
  input  logic             cmpDone,
  input  logic             cmpPass,
  output logic             busy,
  output logic [TAP_W-1:0] delayTap,
  output logic             calErr
);

  calStrobeT        strb;
  logic             tapAtMax;
  logic [TAP_W-1:0] sweepTap, appliedTap;

  eyeCalCtrl #(.SETTLE_CYC(SETTLE_CYC), .IV_W(IV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .calStart(calStart), .intervalCfg(intervalCfg),
    .idleGrant(idleGrant), .cmpDone(cmpDone), .tapAtMax(tapAtMax),
    .strb(strb), .calReq(calReq), .cmpReq(cmpReq), .busy(busy)
  );

  eyeCalPath #(.TAP_W(TAP_W), .MIN_RUN(MIN_RUN), .RESET_TAP(RESET_TAP)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpPass(cmpPass),
    .tapAtMax(tapAtMax), .sweepTap(sweepTap), .appliedTap(appliedTap),
    .calErr(calErr)
  );

  // the sweep tap reaches the line only while sweeping
  assign delayTap = busy ? sweepTap : appliedTap;

endmodule

// File: rtl/eyeCalChecker.sv
module eyeCalChecker #(
  parameter int TAP_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             calReq,
  input logic             cmpReq,
  input logic [TAP_W-1:0] delayTap
);

  a_r7_tap_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(delayTap));

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(delayTap)) |-> delayTap == $past(delayTap) + TAP_W'(1));

  a_r3_sweep_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> delayTap == '0);

  a_r4_cmp_only_in_sweep: assert property (@(posedge clk) disable iff (!rstN)
    cmpReq |-> busy);

  a_r7_claim_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> calReq);

  a_r2_request_precedes_sweep: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(calReq));

endmodule

bind eyeCenterCal eyeCalChecker #(.TAP_W(TAP_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .calReq(calReq),
  .cmpReq(cmpReq), .delayTap(delayTap)
);

// File: tb/tb_eyeCenterCal.sv
module tb_eyeCenterCal;

  localparam int TAP_W = 6;
  localparam int IV_W  = 16;
  localparam int NTAPS = 64;
  localparam int SETTLE = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             calStart = 1'b0;
  logic [IV_W-1:0]  intervalCfg = '0;
  logic             idleGrant = 1'b0;
  logic             cmpDone = 1'b0;
  logic             cmpPass = 1'b0;
  logic             calReq, cmpReq, busy, calErr;
  logic [TAP_W-1:0] delayTap;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;
  int curTap  = 32;
  bit curErr  = 1'b0;

  always #5 clk = ~clk;

  eyeCenterCal dut (
    .clk(clk), .rstN(rstN), .calStart(calStart), .intervalCfg(intervalCfg),
    .idleGrant(idleGrant), .calReq(calReq), .cmpReq(cmpReq), .cmpDone(cmpDone),
    .cmpPass(cmpPass), .busy(busy), .delayTap(delayTap), .calErr(calErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // longest run of passes, earliest on ties, minimum length 2
  task automatic expected(input logic [NTAPS-1:0] m, input int prev,
                          output int tap, output bit err);
    int best = 0, bs = 0, run = 0, rs = 0;
    for (int t = 0; t < NTAPS; t++) begin
      if (m[t]) begin
        if (run == 0) rs = t;
        run++;
        if (run > best) begin best = run; bs = rs; end
      end else run = 0;
    end
    if (best >= 2) begin tap = bs + (best - 1) / 2; err = 1'b0; end
    else begin tap = prev; err = 1'b1; end
  endtask

  function automatic logic [NTAPS-1:0] span(input int lo, input int hi);
    logic [NTAPS-1:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return m;
  endfunction

  // one full calibration; called at a negedge with the block idle
  // (or with calReq already raised when useStart is 0)
  task automatic runCal(input logic [NTAPS-1:0] mask, input bit useStart);
    int expTap, waitCnt;
    bit expErr;
    expected(mask, curTap, expTap, expErr);
    if (useStart) begin
      calStart = 1'b1;
      @(negedge clk);
      calStart = 1'b0;
      check(calReq == 1'b1, "R2 calReq after start pulse", calReq, 1);
    end
    for (int i = 0; i < 4; i++) begin
      check(busy == 1'b0 && cmpReq == 1'b0, "R2 no sweep before grant", busy, 0);
      check(delayTap == curTap, "R2 tap held before grant", delayTap, curTap);
      @(negedge clk);
    end
    idleGrant = 1'b1;
    waitCnt = 0;
    for (int t = 0; t < NTAPS; t++) begin
      do begin
        @(negedge clk);
        if (!cmpReq) waitCnt++;
      end while (!cmpReq);
      check(waitCnt == SETTLE, "R4 settle cycles before compare", waitCnt, SETTLE);
      check(delayTap == t, "R3 sweep tap order", delayTap, t);
      check(busy == 1'b1, "R7 busy during sweep", busy, 1);
      cmpDone = 1'b1;
      cmpPass = mask[t];
      @(negedge clk);
      cmpDone = 1'b0;
      cmpPass = 1'b0;
      waitCnt = 1;
    end
    check(busy == 1'b1, "R7 busy in final cycle", busy, 1);
    @(negedge clk);
    idleGrant = 1'b0;
    check(busy == 1'b0 && calReq == 1'b0, "R7 busy and calReq drop", busy, 0);
    check(delayTap == expTap, "R5 applied tap at window middle", delayTap, expTap);
    check(calErr == expErr, "R6 error flag", calErr, expErr);
    curTap = expTap;
    curErr = expErr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [NTAPS-1:0] lfsr = 64'hC3A5_9E17_5B2D_4F81;
    int idleCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(delayTap == 32, "R1 reset tap", delayTap, 32);
    check(busy == 0 && calReq == 0 && cmpReq == 0, "R1 reset controls", busy, 0);
    check(calErr == 1'b0, "R1 reset error flag", calErr, 0);
    @(negedge clk);

    runCal(span(10, 20), 1'b1);                 // R5 plain window -> 15
    runCal('0, 1'b1);                           // R6 no pass -> keep, error
    runCal(span(5, 9) | span(30, 44), 1'b1);    // R5 longest of two, R6 clear error
    runCal(span(3, 6) | span(20, 23), 1'b1);    // R5 tie -> earliest
    runCal(span(2, 2) | span(4, 4) | span(6, 6) | span(50, 63), 1'b1); // R5 run at top end
    runCal({32{2'b10}}, 1'b1);                  // R6 singles only -> keep, error
    runCal('1, 1'b1);                           // R5 all pass -> 31
    runCal(span(0, 1), 1'b1);                   // R6 minimum run at bottom end -> 0
    runCal(span(62, 63), 1'b1);                 // R5 minimum run at top -> 62
    runCal(span(63, 63), 1'b1);                 // R6 lone pass at top -> error
    for (int k = 0; k < 6; k++) begin
      for (int s = 0; s < 7; s++)
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      runCal(lfsr | (lfsr >> 1), 1'b1);         // R5 pseudo-random windows
    end

    // R8 interval timer: armed during a sweep, counted from the first idle cycle
    intervalCfg = 16'd40;
    runCal(span(20, 40), 1'b1);
    idleCnt = 1;
    while (!calReq) begin
      @(negedge clk);
      if (!calReq) idleCnt++;
    end
    check(idleCnt == 40, "R8 idle cycles before timer request", idleCnt, 40);
    intervalCfg = '0;
    runCal(span(8, 30), 1'b0);
    for (int i = 0; i < 300; i++) begin
      if (calReq) check(1'b0, "R8 disabled timer stays quiet", calReq, 0);
      @(negedge clk);
    end
    check(calReq == 1'b0 && delayTap == curTap, "R8 no request with interval 0", calReq, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule